// File: doc/BRIEF.md
# Flash Erase-and-Program Sequencer

This block rewrites a small on-chip configuration flash without processor help. A program command makes it open the write protection of every sector, clear the sectors one after another, copy a fixed-size image word by word from external memory into the flash, and finally close the protection again. A readback command copies the whole flash image out to external memory instead.

The block drives three independent 32-bit request/acknowledge master ports: one to the flash control and status registers, one to the flash data space and one to the external memory. Exactly one access is in flight at any time. Completion is signalled by a single-cycle `done` pulse. `error` reports whether the last program run saw a failed erase or a failed word write.

Top module: `flash_update_seq`

## Requirements
- R1: On a program command, the control register (register address 4) is read once, the per-sector write-protect bits (control bits 23 upward, one bit per sector, four sectors by default) are cleared with every other bit kept, and the result is written back in one access.
- R2: After that write, the status register (register address 0) is polled until its state field in bits 1:0 reads 0 (idle). No erase starts before then.
- R3: Sectors are cleared in order 0,1,2,3. For sector s the control register is read and written back with bits 22:20 equal to s+1 and all other bits unchanged.
- R4: After each erase write the status register is polled while bits 1:0 read 1 (erase busy). If status bit 4 (erase good) is then clear, no further sector is erased, no word is programmed and `error` is set.
- R5: Programming writes word i, read from memory address base+4i, to flash data address 4i, for i from 0 up to the image size divided by 4, minus 1.
- R6: After every programmed word the status register is read. If bit 3 (write good) is clear, no further word is written and `error` is set.
- R7: Every program run, with or without a failure, ends with a read of the control register and a write back with bits 22:20 all ones and all write-protect bits set, with the other bits kept.
- R8: A readback command copies flash data address 4i to memory address base+4i for every word of the image, leaves `error` clear, and sets `result_bytes` to the image size in bytes.
- R9: `done` is high for exactly one cycle after the last access of a command is acknowledged. After reset, `done`, `error` and all requests are low.
- R10: At most one request is high at a time. Each request and its address, data and direction stay unchanged until its acknowledge.
- R11: Both commands and the base input are ignored while a command is running. A program command wins over a readback command raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Start an erase-and-program run |
| read_start | input | 1 | Start a full-image readback |
| mem_base | input | 32 | Byte base address in external memory, sampled at start |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last program run saw a failed erase or write |
| result_bytes | output | 32 | Byte count of the last readback |
| csr_req | output | 1 | Register port request |
| csr_we | output | 1 | Register port write enable |
| csr_addr | output | 32 | Register byte address (0 status, 4 control) |
| csr_wdata | output | 32 | Register write data |
| csr_ack | input | 1 | Register port acknowledge |
| csr_rdata | input | 32 | Register read data, valid with acknowledge |
| fd_req | output | 1 | Flash data port request |
| fd_we | output | 1 | Flash data port write enable |
| fd_addr | output | 32 | Flash data byte address |
| fd_wdata | output | 32 | Flash data write word |
| fd_ack | input | 1 | Flash data port acknowledge |
| fd_rdata | input | 32 | Flash data read word |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Memory port acknowledge |
| mem_rdata | input | 32 | Memory read word |

## Verification
The bench builds the block with an image size of 32 bytes (eight words) and keeps four sectors and the default field positions. The short image makes a complete run only about a hundred cycles long. That leaves room for a clean program run, a readback, an erase failure in the second sector, a write failure on the fourth word, and commands raised during a run, each with the polling loops and the final re-protect write played out in full.

// File: rtl/fupd_pkg.sv
`timescale 1ns/1ps
package fupd_pkg;

  localparam int NPORT  = 3;
  localparam int P_CSR  = 0;
  localparam int P_FD   = 1;
  localparam int P_MEM  = 2;

  localparam logic [31:0] CSR_STATUS = 32'h0;
  localparam logic [31:0] CSR_CTRL   = 32'h4;

  localparam logic [1:0] ST_IDLE       = 2'd0;
  localparam logic [1:0] ST_ERASE_BUSY = 2'd1;
  localparam int         BIT_WRITE_OK  = 3;
  localparam int         BIT_ERASE_OK  = 4;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
  } acc_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UNP_RD,
    S_UNP_WR,
    S_WAIT_IDLE,
    S_ER_RD,
    S_ER_WR,
    S_ER_POLL,
    S_PG_MRD,
    S_PG_FWR,
    S_PG_CHK,
    S_PR_RD,
    S_PR_WR,
    S_RB_FRD,
    S_RB_MWR
  } seq_state_t;

endpackage

// File: rtl/fupd_master.sv
`timescale 1ns/1ps
module fupd_master
  import fupd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  acc_t cmd,
  input  logic ack,
  output logic req,
  output acc_t held,
  output logic rsp
);

  logic req_q, req_d;
  acc_t held_q;

  always_comb begin
    req_d = req_q;
    if (req_q && ack) req_d = 1'b0;
    if (issue)        req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (issue) held_q <= cmd;
  end

  assign req  = req_q;
  assign held = held_q;
  assign rsp  = req_q && ack;

  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> (req_q && $stable(held_q)));

  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!req_q || ack));

endmodule

// File: rtl/fupd_seq.sv
`timescale 1ns/1ps
module fupd_seq
  import fupd_pkg::*;
#(
  parameter int          NUM_SECTORS = 4,
  parameter logic [31:0] IMAGE_BYTES = 32'h39800,
  parameter int          WP_LSB      = 23,
  parameter int          ER_LSB      = 20,
  parameter int          ER_W        = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prog_start,
  input  logic                        read_start,
  input  logic [31:0]                 mem_base,
  input  logic [NPORT-1:0]            rsp,
  input  logic [NPORT-1:0][31:0]      rdata,
  output logic [NPORT-1:0]            issue,
  output acc_t                        cmd,
  output logic                        done,
  output logic                        error,
  output logic [31:0]                 result_bytes
);

  localparam int          SEC_W    = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(NUM_SECTORS - 1);
  localparam logic [31:0] WP_MASK  = ((32'd1 << NUM_SECTORS) - 32'd1) << WP_LSB;
  localparam logic [31:0] ER_MASK  = ((32'd1 << ER_W) - 32'd1) << ER_LSB;
  localparam logic [31:0] LAST_OFF = IMAGE_BYTES - 32'd4;

  seq_state_t       st_q, st_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [31:0]      off_q, off_d;
  logic [31:0]      base_q, base_d;
  logic [31:0]      res_q, res_d;
  logic             err_q, err_d;
  logic             done_q, done_d;

  logic             launch;
  int               lport;
  acc_t             lcmd;
  logic [31:0]      ctrl_new;
  logic [1:0]       stat_state;

  function automatic acc_t rd(input logic [31:0] a);
    rd = '{we: 1'b0, addr: a, wdata: 32'd0};
  endfunction

  function automatic acc_t wr(input logic [31:0] a, input logic [31:0] d);
    wr = '{we: 1'b1, addr: a, wdata: d};
  endfunction

  assign stat_state = rdata[P_CSR][1:0];

  // next-state process
  always_comb begin
    st_d     = st_q;
    sec_d    = sec_q;
    off_d    = off_q;
    base_d   = base_q;
    res_d    = res_q;
    err_d    = err_q;
    done_d   = 1'b0;
    launch   = 1'b0;
    lport    = P_CSR;
    lcmd     = '0;
    ctrl_new = '0;
    unique case (st_q)
      S_IDLE: begin
        if (prog_start) begin
          err_d  = 1'b0;
          sec_d  = '0;
          off_d  = '0;
          base_d = mem_base;
          st_d   = S_UNP_RD;
          launch = 1'b1; lport = P_CSR; lcmd = rd(CSR_CTRL);
        end else if (read_start) begin
          err_d  = 1'b0;
          off_d  = '0;
          base_d = mem_base;
          st_d   = S_RB_FRD;
          launch = 1'b1; lport = P_FD; lcmd = rd(32'd0);
        end
      end
      S_UNP_RD: if (rsp[P_CSR]) begin
        ctrl_new = rdata[P_CSR] & ~WP_MASK;
        st_d   = S_UNP_WR;
        launch = 1'b1; lport = P_CSR; lcmd = wr(CSR_CTRL, ctrl_new);
      end
      S_UNP_WR: if (rsp[P_CSR]) begin
        st_d   = S_WAIT_IDLE;
        launch = 1'b1; lport = P_CSR; lcmd = rd(CSR_STATUS);
      end
      S_WAIT_IDLE: if (rsp[P_CSR]) begin
        launch = 1'b1; lport = P_CSR;
        if (stat_state == ST_IDLE) begin
          st_d = S_ER_RD; lcmd = rd(CSR_CTRL);
        end else begin
          lcmd = rd(CSR_STATUS);
        end
      end
      S_ER_RD: if (rsp[P_CSR]) begin
        ctrl_new = (rdata[P_CSR] & ~ER_MASK) |
                   (((32'(sec_q) + 32'd1) << ER_LSB) & ER_MASK);
        st_d   = S_ER_WR;
        launch = 1'b1; lport = P_CSR; lcmd = wr(CSR_CTRL, ctrl_new);
      end
      S_ER_WR: if (rsp[P_CSR]) begin
        st_d   = S_ER_POLL;
        launch = 1'b1; lport = P_CSR; lcmd = rd(CSR_STATUS);
      end
      S_ER_POLL: if (rsp[P_CSR]) begin
        launch = 1'b1;
        if (stat_state == ST_ERASE_BUSY) begin
          lport = P_CSR; lcmd = rd(CSR_STATUS);
        end else if (!rdata[P_CSR][BIT_ERASE_OK]) begin
          err_d = 1'b1;
          st_d  = S_PR_RD; lport = P_CSR; lcmd = rd(CSR_CTRL);
        end else if (sec_q == LAST_SEC) begin
          st_d  = S_PG_MRD; lport = P_MEM; lcmd = rd(base_q);
        end else begin
          sec_d = sec_q + 1'b1;
          st_d  = S_ER_RD; lport = P_CSR; lcmd = rd(CSR_CTRL);
        end
      end
      S_PG_MRD: if (rsp[P_MEM]) begin
        st_d   = S_PG_FWR;
        launch = 1'b1; lport = P_FD; lcmd = wr(off_q, rdata[P_MEM]);
      end
      S_PG_FWR: if (rsp[P_FD]) begin
        st_d   = S_PG_CHK;
        launch = 1'b1; lport = P_CSR; lcmd = rd(CSR_STATUS);
      end
      S_PG_CHK: if (rsp[P_CSR]) begin
        launch = 1'b1;
        if (!rdata[P_CSR][BIT_WRITE_OK]) begin
          err_d = 1'b1;
          st_d  = S_PR_RD; lport = P_CSR; lcmd = rd(CSR_CTRL);
        end else if (off_q == LAST_OFF) begin
          st_d  = S_PR_RD; lport = P_CSR; lcmd = rd(CSR_CTRL);
        end else begin
          off_d = off_q + 32'd4;
          st_d  = S_PG_MRD; lport = P_MEM; lcmd = rd(base_q + off_d);
        end
      end
      S_PR_RD: if (rsp[P_CSR]) begin
        ctrl_new = rdata[P_CSR] | ER_MASK | WP_MASK;
        st_d   = S_PR_WR;
        launch = 1'b1; lport = P_CSR; lcmd = wr(CSR_CTRL, ctrl_new);
      end
      S_PR_WR: if (rsp[P_CSR]) begin
        done_d = 1'b1;
        st_d   = S_IDLE;
      end
      S_RB_FRD: if (rsp[P_FD]) begin
        st_d   = S_RB_MWR;
        launch = 1'b1; lport = P_MEM; lcmd = wr(base_q + off_q, rdata[P_FD]);
      end
      S_RB_MWR: if (rsp[P_MEM]) begin
        if (off_q == LAST_OFF) begin
          done_d = 1'b1;
          res_d  = IMAGE_BYTES;
          st_d   = S_IDLE;
        end else begin
          off_d  = off_q + 32'd4;
          st_d   = S_RB_FRD;
          launch = 1'b1; lport = P_FD; lcmd = rd(off_d);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) issue[p] = launch && (lport == p);
  end
  assign cmd = lcmd;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sec_q  <= '0;
      off_q  <= '0;
      base_q <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sec_q  <= sec_d;
      off_q  <= off_d;
      base_q <= base_d;
      res_q  <= res_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign done         = done_q;
  assign error        = err_q;
  assign result_bytes = res_q;

  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_start_ignored_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && (prog_start || read_start)) |=> $stable(base_q));

endmodule

// File: rtl/flash_update_seq.sv
`timescale 1ns/1ps
module flash_update_seq
  import fupd_pkg::*;
#(
  parameter int          NUM_SECTORS = 4,
  parameter logic [31:0] IMAGE_BYTES = 32'h39800,
  parameter int          WP_LSB      = 23,
  parameter int          ER_LSB      = 20,
  parameter int          ER_W        = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_start,
  input  logic        read_start,
  input  logic [31:0] mem_base,
  output logic        done,
  output logic        error,
  output logic [31:0] result_bytes,
  output logic        csr_req,
  output logic        csr_we,
  output logic [31:0] csr_addr,
  output logic [31:0] csr_wdata,
  input  logic        csr_ack,
  input  logic [31:0] csr_rdata,
  output logic        fd_req,
  output logic        fd_we,
  output logic [31:0] fd_addr,
  output logic [31:0] fd_wdata,
  input  logic        fd_ack,
  input  logic [31:0] fd_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);

  localparam logic [31:0] FINAL_BITS =
    (((32'd1 << NUM_SECTORS) - 32'd1) << WP_LSB) | (((32'd1 << ER_W) - 32'd1) << ER_LSB);

  logic [NPORT-1:0]       issue_v, ack_v, req_v, rsp_v;
  logic [NPORT-1:0][31:0] rdata_v;
  acc_t                   held_v [NPORT];
  acc_t                   cmd;

  assign ack_v   = {mem_ack, fd_ack, csr_ack};
  assign rdata_v = {mem_rdata, fd_rdata, csr_rdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    fupd_master u_master (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (issue_v[p]),
      .cmd   (cmd),
      .ack   (ack_v[p]),
      .req   (req_v[p]),
      .held  (held_v[p]),
      .rsp   (rsp_v[p])
    );
  end

  fupd_seq #(
    .NUM_SECTORS (NUM_SECTORS),
    .IMAGE_BYTES (IMAGE_BYTES),
    .WP_LSB      (WP_LSB),
    .ER_LSB      (ER_LSB),
    .ER_W        (ER_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_start   (prog_start),
    .read_start   (read_start),
    .mem_base     (mem_base),
    .rsp          (rsp_v),
    .rdata        (rdata_v),
    .issue        (issue_v),
    .cmd          (cmd),
    .done         (done),
    .error        (error),
    .result_bytes (result_bytes)
  );

  assign csr_req   = req_v[P_CSR];
  assign csr_we    = held_v[P_CSR].we;
  assign csr_addr  = held_v[P_CSR].addr;
  assign csr_wdata = held_v[P_CSR].wdata;
  assign fd_req    = req_v[P_FD];
  assign fd_we     = held_v[P_FD].we;
  assign fd_addr   = held_v[P_FD].addr;
  assign fd_wdata  = held_v[P_FD].wdata;
  assign mem_req   = req_v[P_MEM];
  assign mem_we    = held_v[P_MEM].we;
  assign mem_addr  = held_v[P_MEM].addr;
  assign mem_wdata = held_v[P_MEM].wdata;

  p_one_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csr_req, fd_req, mem_req}));

  p_no_flash_write_after_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !(fd_req && fd_we));

  p_final_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (u_seq.st_q == S_PR_WR && csr_req && csr_ack) |->
      (csr_we && csr_addr == CSR_CTRL && (csr_wdata & FINAL_BITS) == FINAL_BITS));

endmodule

// File: tb/flash_update_seq_bench.sv
`timescale 1ns/1ps
module flash_update_seq_bench;

  localparam logic [31:0] IMG   = 32'd32;
  localparam int          WORDS = 8;
  localparam logic [31:0] WPM   = 32'h0780_0000;  // write-protect bits 26:23
  localparam logic [31:0] ERM   = 32'h0070_0000;  // erase field 22:20
  localparam logic [31:0] C0    = 32'h17F0_00A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        prog_start = 1'b0, read_start = 1'b0;
  logic [31:0] mem_base = 32'd0;
  logic        done, error;
  logic [31:0] result_bytes;
  logic        csr_req, csr_we, fd_req, fd_we, mem_req, mem_we;
  logic [31:0] csr_addr, csr_wdata, fd_addr, fd_wdata, mem_addr, mem_wdata;
  logic        csr_ack = 1'b0, fd_ack = 1'b0, mem_ack = 1'b0;
  logic [31:0] csr_rdata = '0, fd_rdata = '0, mem_rdata = '0;

  flash_update_seq #(.IMAGE_BYTES(IMG)) u_flash_update_seq (.*);

  int checks = 0, errors = 0, cyc = 0, viol = 0;

  typedef struct { int port; logic [31:0] addr; logic [31:0] data; } item_t;
  item_t exq[$];

  // ---------------- models ----------------
  logic [31:0] ctrl_m = C0;
  logic [31:0] flash_m [WORDS];
  logic [31:0] mem_m [128];
  int  busy_cnt = 0, lat_seed = 0, fault_sec = -1, fault_word = -1;
  logic [1:0] busy_kind = 2'd0;
  logic erase_ok = 1'b1, write_ok = 1'b1, idle_seen = 1'b0;
  int  lat [3] = '{0, 0, 0};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      // register port
      if (csr_ack) csr_ack <= 1'b0;
      else if (csr_req) begin
        if (lat[0] == 0) begin
          csr_ack <= 1'b1; lat[0] = lat_seed % 3; lat_seed++;
          if (!csr_we) begin
            if (csr_addr == 32'h4) csr_rdata <= ctrl_m;
            else begin
              csr_rdata <= {27'd0, erase_ok, write_ok, 1'b0, (busy_cnt > 0) ? busy_kind : 2'd0};
              if (busy_cnt > 0) busy_cnt--; else idle_seen = 1'b1;
            end
          end else begin
            if (csr_wdata[22:20] >= 3'd1 && csr_wdata[22:20] <= 3'd4) begin
              chk("R2", "idle seen before erase", {31'd0, idle_seen}, 32'd1);
              chk("R4", "previous erase polled out", busy_cnt, 0);
              busy_kind = 2'd1; busy_cnt = 3;
              erase_ok = (int'(csr_wdata[22:20]) - 1) != fault_sec;
            end else if ((csr_wdata & WPM) == 32'd0) begin
              busy_kind = 2'd2; busy_cnt = 2; idle_seen = 1'b0;
            end
            ctrl_m = csr_wdata;
          end
        end else lat[0]--;
      end
      // flash data port
      if (fd_ack) fd_ack <= 1'b0;
      else if (fd_req) begin
        if (lat[1] == 0) begin
          fd_ack <= 1'b1; lat[1] = lat_seed % 3; lat_seed++;
          if (fd_we) begin
            chk("R4", "erase finished before program", busy_cnt, 0);
            flash_m[fd_addr[4:2]] = fd_wdata;
            write_ok = int'(fd_addr[4:2]) != fault_word;
          end else fd_rdata <= flash_m[fd_addr[4:2]];
        end else lat[1]--;
      end
      // memory port
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (lat[2] == 0) begin
          mem_ack <= 1'b1; lat[2] = lat_seed % 3; lat_seed++;
          if (mem_we) mem_m[mem_addr[8:2]] = mem_wdata;
          else mem_rdata <= mem_m[mem_addr[8:2]];
        end else lat[2]--;
      end
    end
  end

  // ---------------- monitor / scoreboard ----------------
  task automatic compare(input int port, input logic [31:0] a, input logic [31:0] d);
    item_t e;
    checks++;
    if (exq.size() == 0) begin
      errors++;
      $display("FAIL R11 unexpected write port %0d addr %h: actual %h expected none", port, a, d);
    end else begin
      e = exq.pop_front();
      if (e.port != port || e.addr !== a || e.data !== d) begin
        errors++;
        $display("FAIL R1/R3/R5/R7/R8 write: actual port %0d addr %h data %h expected port %0d addr %h data %h",
                 port, a, d, e.port, e.addr, e.data);
      end
    end
  endtask

  logic [2:0]  p_req, p_ack;
  logic [31:0] p_addr [3];
  always @(posedge clk) begin
    if (rst_n) begin
      if (csr_req && csr_ack && csr_we) compare(0, csr_addr, csr_wdata);
      if (fd_req && fd_ack && fd_we)    compare(1, fd_addr, fd_wdata);
      if (mem_req && mem_ack && mem_we) compare(2, mem_addr, mem_wdata);
      // R10: a request never drops or moves before its acknowledge
      if (p_req[0] && !p_ack[0] && (!csr_req || csr_addr != p_addr[0])) viol++;
      if (p_req[1] && !p_ack[1] && (!fd_req || fd_addr != p_addr[1])) viol++;
      if (p_req[2] && !p_ack[2] && (!mem_req || mem_addr != p_addr[2])) viol++;
      if ((32'(csr_req) + 32'(fd_req) + 32'(mem_req)) > 1) viol++;
    end
    p_req  <= {mem_req, fd_req, csr_req};
    p_ack  <= {mem_ack, fd_ack, csr_ack};
    p_addr <= '{csr_addr, fd_addr, mem_addr};
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic push(input int port, input logic [31:0] a, input logic [31:0] d);
    item_t e;
    e.port = port; e.addr = a; e.data = d;
    exq.push_back(e);
  endtask

  task automatic expect_program(input logic [31:0] base, input int fsec, input int fword);
    logic [31:0] c;
    c = ctrl_m & ~WPM;
    push(0, 32'h4, c);                                   // R1
    for (int s = 0; s < 4; s++) begin                    // R3
      c = (c & ~ERM) | (32'(s + 1) << 20);
      push(0, 32'h4, c);
      if (s == fsec) break;
    end
    if (fsec < 0) begin
      for (int i = 0; i < WORDS; i++) begin              // R5
        push(1, 32'(4 * i), mem_m[(base >> 2) + 32'(i)]);
        if (i == fword) break;
      end
    end
    push(0, 32'h4, c | ERM | WPM);                       // R7
  endtask

  task automatic pulse(input logic p, input logic r, input logic [31:0] base);
    @(negedge clk);
    prog_start = p; read_start = r; mem_base = base;
    @(negedge clk);
    prog_start = 1'b0; read_start = 1'b0;
  endtask

  task automatic wait_done(input string req, input logic exp_err);
    int n = 0;
    while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(req, "done raised", {31'd0, done}, 32'd1);
    chk(req, "error level", {31'd0, error}, {31'd0, exp_err});
    chk(req, "scoreboard drained", exq.size(), 0);
    @(negedge clk);
    chk("R9", "done one cycle", {31'd0, done}, 32'd0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem_m[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    for (int i = 0; i < WORDS; i++) flash_m[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "done after reset", {31'd0, done}, 32'd0);
    chk("R9", "error after reset", {31'd0, error}, 32'd0);
    chk("R9", "requests after reset", {29'd0, csr_req, fd_req, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // nominal program run: R1 R2 R3 R5 R7
    expect_program(32'h100, -1, -1);
    pulse(1'b1, 1'b0, 32'h100);
    wait_done("R5", 1'b0);
    chk("R7", "control re-protected", ctrl_m, C0);

    // readback: R8
    for (int i = 0; i < WORDS; i++) push(2, 32'h40 + 32'(4 * i), flash_m[i]);
    pulse(1'b0, 1'b1, 32'h40);
    wait_done("R8", 1'b0);
    chk("R8", "result bytes", result_bytes, IMG);

    // erase failure in sector 1: R4
    fault_sec = 1;
    expect_program(32'h100, 1, -1);
    pulse(1'b1, 1'b0, 32'h100);
    wait_done("R4", 1'b1);
    chk("R7", "control re-protected after erase fail", ctrl_m, C0);
    fault_sec = -1;

    // write failure on word 3: R6
    fault_word = 3;
    expect_program(32'h140, -1, 3);
    pulse(1'b1, 1'b0, 32'h140);
    wait_done("R6", 1'b1);
    fault_word = -1;

    // commands during a run are ignored: R11
    expect_program(32'h180, -1, -1);
    pulse(1'b1, 1'b0, 32'h180);
    repeat (30) @(negedge clk);
    pulse(1'b1, 1'b1, 32'h0);
    wait_done("R11", 1'b0);

    // simultaneous commands, program wins: R11
    expect_program(32'h100, -1, -1);
    pulse(1'b1, 1'b1, 32'h100);
    wait_done("R11", 1'b0);
    chk("R8", "result bytes kept after program", result_bytes, IMG);

    chk("R10", "request handshake violations", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule